// File: doc/BRIEF.md
# Windowed Register Bridge for a USB OTG Glue Device

This block is the bus slave at the front of a USB on-the-go glue device. It sees host accesses through a 12-bit offset space and sends each one to one of three places. Offsets 0x400–0x5FF pass straight through to an embedded USB core. Offsets 0x600–0x7FF are remapped onto that core's per-endpoint FIFO addresses. Offsets from 0x800 upward are a bank of 32-bit system registers kept inside the bridge.

Forwarded accesses go out on a core port with a single-cycle request/ready handshake. Local accesses complete at once. Every accepted access gets exactly one response in the following cycle.

Writes to the endpoint transfer-size registers are also turned into a one-cycle side-band command to the core. The command carries the endpoint number, the transfer size and the direction. Identification words are hard-wired. The host-mode bit of the device configuration register drives an output pin. Illegal accesses are answered with an error flag and leave all state untouched.

Top module: `usb_glue_regbridge`

## Requirements
- R1: Only the low 12 bits of `req_addr` select the target; the bits above them have no effect on decode, translation or storage.
- R2: An access to offsets 0x400–0x5FF is forwarded. `core_valid` follows `req_valid`, and `core_addr` is offset bits 8:0. Write flag, size and write data pass unchanged. An access outside 0x400–0x7FF never raises `core_valid`.
- R3: An access to offsets 0x600–0x7FF is forwarded with `core_addr` = 0x20 + ((offset >> 3) & 0x3C), which maps each 32-byte slice onto one endpoint FIFO word.
- R4: A forwarded access is accepted on the edge where `req_valid` and `core_ready` are both high, and `req_ready` mirrors `core_ready`. A local or unmapped access is accepted on its first edge. `rsp_valid` is high in exactly the cycle after each acceptance. `rsp_rdata` then holds the `core_rdata` sampled at acceptance (forwarded read), the register value (local read), or zero (any write).
- R5: The device-config word (0x800), the scratch word (0x9C4) and nine plain configuration words store all 32 bits, read back what was written, and reset to zero. The nine plain words are at 0x818, 0x81C, 0x82C, 0x830, 0x834, 0x83C, 0x884, 0x904 and 0x948. Local registers are word-addressed: offset bits 1:0 are ignored.
- R6: The production-test word at 0x9D8 resets to 0x0000A596 and is read/write.
- R7: Fixed words read 0x20 at 0x814 and 0x838, 0x30 at 0x880 and 0x900, 0xA9453C59 at 0x9F8 and 0x54059ADF at 0x9FC. Writes to them are ignored.
- R8: Any other offset reads zero, ignores writes and raises no error.
- R9: A write to the endpoint-0 word (0x908) stores bits 8:0 only (upper bits read zero). One cycle later it pulses `upd_valid` with `upd_ep` = 0, `upd_len` = data bits 6:0 and `upd_tx` = data bit 7.
- R10: A write to IN-size slot k (0x90C + 4k) or OUT-size slot k (0x94C + 4k), k = 0..N_EP-1, stores 32 bits. One cycle later it pulses `upd_valid` with `upd_ep` = k+1 and `upd_len` = data bits 30:0. `upd_tx` is 1 for IN and 0 for OUT. No other access raises `upd_valid`.
- R11: `host_mode` shows bit 16 of the device-config word. A write to that word with bit 15 set is rejected: `rsp_err` is raised and nothing changes.
- R12: A local-region access (offset ≥ 0x800) whose `req_size` is not 2 (0 = byte, 1 = halfword, 2 = word, 3 = reserved) is answered with `rsp_err`. It returns zero, changes no state and sends no size update. Word accesses to the local region never raise `rsp_err`.
- R13: After reset `rsp_valid`, `rsp_err`, `upd_valid` and `host_mode` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host access request |
| req_ready | output | 1 | Request accepted on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Host address; low 12 bits decoded |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | Access rejected |
| core_valid | output | 1 | Forwarded request to the USB core |
| core_ready | input | 1 | Core accepts the forwarded request |
| core_write | output | 1 | Forwarded write flag |
| core_addr | output | 9 | Translated core address |
| core_size | output | 2 | Forwarded access size |
| core_wdata | output | 32 | Forwarded write data |
| core_rdata | input | 32 | Core read data, valid while core_ready is high |
| upd_valid | output | 1 | Transfer-size update strobe |
| upd_ep | output | EP_W | Endpoint number of the update |
| upd_len | output | 31 | Transfer size |
| upd_tx | output | 1 | 1 = transmit, 0 = receive |
| host_mode | output | 1 | Host-mode selection from device config |

## Verification
The bench builds the block with ADDR_W = 16 and N_EP = 15. The four address bits above the decoded offset are driven at random, which tests that decode ignores them. The full set of fifteen IN and fifteen OUT slots is reachable, including the last slot of each bank, which sits next to the endpoint-map word and the unmapped gap. Forwarded accesses are held for random stretches of `core_ready` low, so the one-response-per-acceptance rule is tested under stalls. Endpoint-0 writes with random upper bits exercise the 9-bit storage mask and the size/direction split.

// File: rtl/usb_glue_pkg.sv
// Package: shared constants and types for the USB glue register bridge.
// Assumes a 12-bit decoded offset and a 32-bit local register bank.
package usb_glue_pkg;

    localparam int OFF_W   = 12;
    localparam int DW      = 32;
    localparam int CORE_AW = 9;
    localparam int N_PLAIN = 9;

    typedef enum logic [1:0] {
        REG_NONE  = 2'd0,
        REG_CORE  = 2'd1,
        REG_FIFO  = 2'd2,
        REG_LOCAL = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    localparam logic [OFF_W-1:0] OFF_DEVCFG   = 12'h800;
    localparam logic [OFF_W-1:0] OFF_EP0      = 12'h908;
    localparam logic [OFF_W-1:0] OFF_IN_BASE  = 12'h90C;
    localparam logic [OFF_W-1:0] OFF_OUT_BASE = 12'h94C;
    localparam logic [OFF_W-1:0] OFF_SCRATCH  = 12'h9C4;
    localparam logic [OFF_W-1:0] OFF_PTEST    = 12'h9D8;
    localparam logic [OFF_W-1:0] OFF_REV_PWR  = 12'h814;
    localparam logic [OFF_W-1:0] OFF_REV_INT  = 12'h838;
    localparam logic [OFF_W-1:0] OFF_REV_GPIO = 12'h880;
    localparam logic [OFF_W-1:0] OFF_REV_DMA  = 12'h900;
    localparam logic [OFF_W-1:0] OFF_ID_LO    = 12'h9F8;
    localparam logic [OFF_W-1:0] OFF_ID_HI    = 12'h9FC;

    localparam logic [DW-1:0] PTEST_RESET = 32'h0000_A596;
    localparam logic [DW-1:0] REV_A       = 32'h0000_0020;
    localparam logic [DW-1:0] REV_B       = 32'h0000_0030;
    localparam logic [DW-1:0] ID_LO_VAL   = 32'hA945_3C59;
    localparam logic [DW-1:0] ID_HI_VAL   = 32'h5405_9ADF;

    localparam int DEVCFG_HOST_BIT  = 16;
    localparam int DEVCFG_PTEST_BIT = 15;
    localparam int EP0_KEEP_W       = 9;
    localparam int EP0_LEN_W        = 7;
    localparam int EP0_DIR_BIT      = 7;
    localparam int LEN_W            = 31;

    // Plain read/write configuration words, no side effects.
    localparam logic [OFF_W-1:0] PLAIN_OFFS [N_PLAIN] = '{
        12'h818, 12'h81C, 12'h82C, 12'h830, 12'h834,
        12'h83C, 12'h884, 12'h904, 12'h948
    };

endpackage

// File: rtl/bridge_window_dec.sv
// Module: bridge_window_dec
// Classifies a 12-bit offset into core, FIFO, local or unmapped region and
// produces the translated core address. Purely combinational.
// Assumes the caller has already dropped address bits above the offset.
module bridge_window_dec
    import usb_glue_pkg::*;
(
    input  logic [OFF_W-1:0]   off,
    output region_e            region,
    output logic [CORE_AW-1:0] core_addr
);

    // FIFO slice index: (off >> 3) & 0x3C keeps offset bits 8:5 at positions 5:2.
    logic [CORE_AW-1:0] fifo_addr;
    assign fifo_addr = CORE_AW'(9'h020) + {{(CORE_AW-6){1'b0}}, off[8:5], 2'b00};

    // Region select and address translation.
    always_comb begin
        region    = REG_NONE;
        core_addr = '0;
        if (off[11]) begin
            region = REG_LOCAL;
        end else if (off[10] && !off[9]) begin
            region    = REG_CORE;
            core_addr = off[CORE_AW-1:0];
        end else if (off[10] && off[9]) begin
            region    = REG_FIFO;
            core_addr = fifo_addr;
        end
    end

endmodule

// File: rtl/bridge_local_bank.sv
// Module: bridge_local_bank
// Local 32-bit system register bank: storage, readback, fixed identification
// words and the endpoint transfer-size update command.
// Assumes wr_en is already qualified (word size, legal value, accepted).
module bridge_local_bank
    import usb_glue_pkg::*;
#(
    parameter int N_EP = 15,
    parameter int EP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OFF_W-1:0] off,
    input  logic             wr_en,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             wr_reject,
    output logic             host_mode,
    output logic             upd_valid,
    output logic [EP_W-1:0]  upd_ep,
    output logic [LEN_W-1:0] upd_len,
    output logic             upd_tx
);

    localparam int SLOT_W = OFF_W - 2;
    localparam logic [OFF_W-1:0] IN_LIM  = OFF_W'(int'(OFF_IN_BASE)  + 4 * N_EP);
    localparam logic [OFF_W-1:0] OUT_LIM = OFF_W'(int'(OFF_OUT_BASE) + 4 * N_EP);

    logic [OFF_W-1:0]  ow;
    logic [OFF_W-1:0]  in_rel, out_rel;
    logic [SLOT_W-1:0] in_slot, out_slot;
    logic              hit_in, hit_out, hit_ep0;
    logic [N_PLAIN-1:0] plain_hit;

    logic [DW-1:0]         devcfg_q, scratch_q, ptest_q;
    logic [EP0_KEEP_W-1:0] ep0_q;
    logic [DW-1:0]         plain_q [N_PLAIN];
    logic [DW-1:0]         in_q    [N_EP];
    logic [DW-1:0]         out_q   [N_EP];

    // Word-aligned offset and endpoint slot decode.
    assign ow       = {off[OFF_W-1:2], 2'b00};
    assign in_rel   = ow - OFF_IN_BASE;
    assign out_rel  = ow - OFF_OUT_BASE;
    assign in_slot  = in_rel[OFF_W-1:2];
    assign out_slot = out_rel[OFF_W-1:2];
    assign hit_in   = (ow >= OFF_IN_BASE)  && (ow < IN_LIM);
    assign hit_out  = (ow >= OFF_OUT_BASE) && (ow < OUT_LIM);
    assign hit_ep0  = (ow == OFF_EP0);

    // One match line per plain configuration word.
    for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain_hit
        assign plain_hit[g] = (ow == PLAIN_OFFS[g]);
    end

    // Production-test enable in a device-config write is not allowed.
    assign wr_reject = (ow == OFF_DEVCFG) && wdata[DEVCFG_PTEST_BIT];
    assign host_mode = devcfg_q[DEVCFG_HOST_BIT];

    // Singleton registers with reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            devcfg_q  <= '0;
            scratch_q <= '0;
            ptest_q   <= PTEST_RESET;
            ep0_q     <= '0;
        end else if (wr_en) begin
            if (ow == OFF_DEVCFG)  devcfg_q  <= wdata;
            if (ow == OFF_SCRATCH) scratch_q <= wdata;
            if (ow == OFF_PTEST)   ptest_q   <= wdata;
            if (hit_ep0)           ep0_q     <= wdata[EP0_KEEP_W-1:0];
        end
    end

    // Plain configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_PLAIN; i++) plain_q[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < N_PLAIN; i++)
                if (plain_hit[i]) plain_q[i] <= wdata;
        end
    end

    // IN and OUT endpoint transfer-size words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_EP; i++) begin
                in_q[i]  <= '0;
                out_q[i] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < N_EP; i++) begin
                if (hit_in  && (in_slot  == SLOT_W'(i))) in_q[i]  <= wdata;
                if (hit_out && (out_slot == SLOT_W'(i))) out_q[i] <= wdata;
            end
        end
    end

    // Size-update command, one cycle after the triggering write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_valid <= 1'b0;
            upd_ep    <= '0;
            upd_len   <= '0;
            upd_tx    <= 1'b0;
        end else begin
            upd_valid <= wr_en && (hit_ep0 || hit_in || hit_out);
            if (wr_en && hit_ep0) begin
                upd_ep  <= '0;
                upd_len <= LEN_W'(wdata[EP0_LEN_W-1:0]);
                upd_tx  <= wdata[EP0_DIR_BIT];
            end else if (wr_en && hit_in) begin
                upd_ep  <= EP_W'(in_slot) + EP_W'(1);
                upd_len <= wdata[LEN_W-1:0];
                upd_tx  <= 1'b1;
            end else if (wr_en && hit_out) begin
                upd_ep  <= EP_W'(out_slot) + EP_W'(1);
                upd_len <= wdata[LEN_W-1:0];
                upd_tx  <= 1'b0;
            end
        end
    end

    // Readback multiplexer; unknown offsets return zero.
    always_comb begin
        rdata = '0;
        unique case (ow)
            OFF_DEVCFG:   rdata = devcfg_q;
            OFF_SCRATCH:  rdata = scratch_q;
            OFF_PTEST:    rdata = ptest_q;
            OFF_EP0:      rdata = DW'(ep0_q);
            OFF_REV_PWR:  rdata = REV_A;
            OFF_REV_INT:  rdata = REV_A;
            OFF_REV_GPIO: rdata = REV_B;
            OFF_REV_DMA:  rdata = REV_B;
            OFF_ID_LO:    rdata = ID_LO_VAL;
            OFF_ID_HI:    rdata = ID_HI_VAL;
            default:      rdata = '0;
        endcase
        for (int i = 0; i < N_PLAIN; i++)
            if (plain_hit[i]) rdata = plain_q[i];
        for (int i = 0; i < N_EP; i++) begin
            if (hit_in  && (in_slot  == SLOT_W'(i))) rdata = in_q[i];
            if (hit_out && (out_slot == SLOT_W'(i))) rdata = out_q[i];
        end
    end

endmodule

// File: rtl/usb_glue_regbridge.sv
// Module: usb_glue_regbridge (top)
// Bus slave that forwards core and FIFO windows to the embedded USB core,
// serves the local register bank, and registers one response per accepted
// access. Assumes req_* are held stable until req_ready is seen high.
module usb_glue_regbridge
    import usb_glue_pkg::*;
#(
    parameter  int ADDR_W = 16,
    parameter  int N_EP   = 15,
    localparam int EP_W   = $clog2(N_EP + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [1:0]         req_size,
    input  logic [DW-1:0]      req_wdata,
    output logic               rsp_valid,
    output logic [DW-1:0]      rsp_rdata,
    output logic               rsp_err,
    output logic               core_valid,
    input  logic               core_ready,
    output logic               core_write,
    output logic [CORE_AW-1:0] core_addr,
    output logic [1:0]         core_size,
    output logic [DW-1:0]      core_wdata,
    input  logic [DW-1:0]      core_rdata,
    output logic               upd_valid,
    output logic [EP_W-1:0]    upd_ep,
    output logic [LEN_W-1:0]   upd_len,
    output logic               upd_tx,
    output logic               host_mode
);

    logic [OFF_W-1:0]   off;
    region_e            region;
    logic [CORE_AW-1:0] xl_addr;
    logic               fwd, is_local, subword, bad, acc, bank_wr, wr_reject;
    logic [DW-1:0]      bank_rdata;

    assign off = req_addr[OFF_W-1:0];

    bridge_window_dec u_dec (
        .off       (off),
        .region    (region),
        .core_addr (xl_addr)
    );

    bridge_local_bank #(.N_EP(N_EP), .EP_W(EP_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .off       (off),
        .wr_en     (bank_wr),
        .wdata     (req_wdata),
        .rdata     (bank_rdata),
        .wr_reject (wr_reject),
        .host_mode (host_mode),
        .upd_valid (upd_valid),
        .upd_ep    (upd_ep),
        .upd_len   (upd_len),
        .upd_tx    (upd_tx)
    );

    // Forwarding path and acceptance qualification.
    assign fwd        = (region == REG_CORE) || (region == REG_FIFO);
    assign is_local   = (region == REG_LOCAL);
    assign core_valid = req_valid && fwd;
    assign core_write = req_write;
    assign core_addr  = xl_addr;
    assign core_size  = req_size;
    assign core_wdata = req_wdata;
    assign req_ready  = fwd ? core_ready : 1'b1;
    assign acc        = req_valid && req_ready;
    assign subword    = (req_size != SZ_WORD);
    assign bad        = is_local && (subword || (req_write && wr_reject));
    assign bank_wr    = acc && req_write && is_local && !bad;

    // Response register: one strobe per accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= acc;
            if (acc) begin
                rsp_err <= bad;
                if (req_write || bad) rsp_rdata <= '0;
                else if (fwd)         rsp_rdata <= core_rdata;
                else                  rsp_rdata <= bank_rdata;
            end else begin
                rsp_err <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/usb_glue_regbridge_chk.sv
// Module: usb_glue_regbridge_chk
// Protocol checker bound to usb_glue_regbridge; observes ports only.
module usb_glue_regbridge_chk #(
    parameter int ADDR_W = 16,
    parameter int N_EP   = 15,
    parameter int EP_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              core_valid,
    input logic [8:0]        core_addr,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              upd_valid,
    input logic [EP_W-1:0]   upd_ep,
    input logic              host_mode
);

    logic acc;
    assign acc = req_valid && req_ready;

    a_r4_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);

    a_r4_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_valid);

    a_r2_core_window_only: assert property (@(posedge clk) disable iff (!rst_n)
        core_valid |-> (req_addr[11:10] == 2'b01));

    a_r3_fifo_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid && req_addr[9]) |->
            (core_addr[1:0] == 2'b00 && core_addr >= 9'h020 && core_addr <= 9'h05C));

    a_r10_upd_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> $past(acc && req_write));

    a_r10_upd_ep_range: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (int'(upd_ep) <= N_EP));

    a_r11_host_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && req_write) |=> $stable(host_mode));

    a_r12_word_local_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_write && req_addr[11] && req_size == 2'd2) |=> !rsp_err);

endmodule

bind usb_glue_regbridge usb_glue_regbridge_chk #(
    .ADDR_W(ADDR_W), .N_EP(N_EP), .EP_W(EP_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .core_valid (core_valid),
    .core_addr  (core_addr),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .upd_valid  (upd_valid),
    .upd_ep     (upd_ep),
    .host_mode  (host_mode)
);

// File: tb/usb_glue_regbridge_tb_top.sv
module usb_glue_regbridge_tb_top;

    localparam int ADDR_W = 16;
    localparam int N_EP   = 15;
    localparam int EP_W   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_size = 2'd2;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid, rsp_err;
    logic [31:0]       rsp_rdata;
    logic              core_valid, core_write;
    logic              core_ready = 1'b0;
    logic [8:0]        core_addr;
    logic [1:0]        core_size;
    logic [31:0]       core_wdata, core_rdata;
    logic              upd_valid, upd_tx, host_mode;
    logic [EP_W-1:0]   upd_ep;
    logic [30:0]       upd_len;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] mreg [0:511];

    always #10 clk = ~clk;

    // Core model: read data is a function of the translated address.
    assign core_rdata = 32'hC0DE_0000 | {23'd0, core_addr};

    usb_glue_regbridge #(.ADDR_W(ADDR_W), .N_EP(N_EP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .core_valid(core_valid), .core_ready(core_ready), .core_write(core_write),
        .core_addr(core_addr), .core_size(core_size), .core_wdata(core_wdata),
        .core_rdata(core_rdata),
        .upd_valid(upd_valid), .upd_ep(upd_ep), .upd_len(upd_len), .upd_tx(upd_tx),
        .host_mode(host_mode)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit is_in(input int o);  return o >= 'h90C && o < 'h90C + 4*N_EP; endfunction
    function automatic bit is_out(input int o); return o >= 'h94C && o < 'h94C + 4*N_EP; endfunction

    function automatic bit is_rw(input int o);
        case (o)
            'h800, 'h818, 'h81C, 'h82C, 'h830, 'h834, 'h83C, 'h884, 'h904,
            'h948, 'h908, 'h9C4, 'h9D8: return 1'b1;
            default: return is_in(o) || is_out(o);
        endcase
    endfunction

    function automatic logic [31:0] exp_local(input int o);
        case (o)
            'h814, 'h838: return 32'h20;
            'h880, 'h900: return 32'h30;
            'h9F8: return 32'hA9453C59;
            'h9FC: return 32'h54059ADF;
            default: return is_rw(o) ? mreg[(o - 'h800) >> 2] : 32'h0;
        endcase
    endfunction

    function automatic logic [8:0] exp_core_addr(input logic [11:0] o);
        if (o[9]) return 9'h020 + 9'((o >> 3) & 12'h03C);
        return o[8:0];
    endfunction

    // One complete access with expected-value checks; dly = core stall cycles.
    task automatic access(input logic [ADDR_W-1:0] a, input bit wr, input logic [1:0] sz,
                          input logic [31:0] wd, input int dly);
        logic [11:0] o;
        int ow;
        bit fwd, loc, bad, eu;
        logic [31:0] er;
        o   = a[11:0];
        ow  = int'({o[11:2], 2'b00});
        fwd = (o[11] == 1'b0) && (o[10] == 1'b1);
        loc = o[11];
        bad = loc && (sz != 2'd2 || (wr && ow == 'h800 && wd[15]));
        if (wr || bad)  er = 32'h0;
        else if (fwd)   er = 32'hC0DE_0000 | {23'd0, exp_core_addr(o)};
        else if (loc)   er = exp_local(ow);
        else            er = 32'h0;
        eu = wr && !bad && loc && (ow == 'h908 || is_in(ow) || is_out(ow));

        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_size = sz; req_wdata = wd;
        core_ready = fwd ? (dly == 0) : 1'b0;
        #2;
        chk(core_valid == fwd, "R2 core_valid window", {31'd0, core_valid}, {31'd0, fwd});
        if (fwd) begin
            chk(core_addr == exp_core_addr(o), o[9] ? "R3 fifo addr" : "R2 core addr",
                {23'd0, core_addr}, {23'd0, exp_core_addr(o)});
            chk(core_write == wr && core_size == sz && core_wdata == wd, "R2 passthrough",
                core_wdata, wd);
        end
        if (fwd) begin
            for (int i = 0; i < dly; i++) begin
                @(negedge clk);
                chk(rsp_valid == 1'b0, "R4 no rsp while stalled", {31'd0, rsp_valid}, 32'd0);
            end
            core_ready = 1'b1;
        end
        @(negedge clk);
        chk(rsp_valid == 1'b1, "R4 rsp strobe", {31'd0, rsp_valid}, 32'd1);
        chk(rsp_err == bad, bad ? "R12/R11 error flag" : "R12 no error", {31'd0, rsp_err}, {31'd0, bad});
        chk(rsp_rdata == er, loc ? "R5/R7 local read" : (fwd ? "R4 fwd read" : "R8 unmapped read"),
            rsp_rdata, er);
        chk(upd_valid == eu, "R10 upd strobe", {31'd0, upd_valid}, {31'd0, eu});
        if (eu) begin
            if (ow == 'h908) begin
                chk(upd_ep == 0 && upd_len == {24'd0, wd[6:0]} && upd_tx == wd[7],
                    "R9 ep0 update", {upd_tx, upd_len}, {wd[7], 24'd0, wd[6:0]});
            end else begin
                int k;
                bit tx;
                tx = is_in(ow);
                k  = tx ? (ow - 'h90C) / 4 : (ow - 'h94C) / 4;
                chk(int'(upd_ep) == k + 1 && upd_len == wd[30:0] && upd_tx == tx,
                    "R10 ep update", {upd_ep, upd_tx, 27'd0}, {4'(k + 1), tx, 27'd0});
            end
        end
        req_valid = 1'b0; core_ready = 1'b0;
        if (wr && !bad && loc && is_rw(ow))
            mreg[(ow - 'h800) >> 2] = (ow == 'h908) ? (wd & 32'h1FF) : wd;
        chk(host_mode == mreg[0][16], "R11 host_mode", {31'd0, host_mode}, {31'd0, mreg[0][16]});
    endtask

    function automatic logic [11:0] pick_local();
        int s;
        s = $urandom_range(0, 12);
        case (s)
            0: return 12'h800;
            1: return 12'h818 + 12'(4 * $urandom_range(0, 1));
            2: return 12'h82C + 12'(4 * $urandom_range(0, 4));
            3: return 12'h884;
            4: return 12'h904 + 12'(4 * $urandom_range(0, 1));
            5: return 12'h90C + 12'(4 * $urandom_range(0, N_EP - 1));
            6: return 12'h94C + 12'(4 * $urandom_range(0, N_EP - 1));
            7: return 12'h9C4;
            8: return 12'h9D8;
            9: return 12'h9F8 + 12'(4 * $urandom_range(0, 1));
            10: return 12'h814;
            11: return 12'(12'h800 + $urandom_range(0, 2047));
            default: return 12'h880;
        endcase
    endfunction

    initial begin
        int dummy;
        dummy = int'($urandom(32'h1F2E_3D4C));
        for (int i = 0; i < 512; i++) mreg[i] = 32'h0;
        mreg[('h9D8 - 'h800) >> 2] = 32'h0000_A596;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(!rsp_valid && !rsp_err && !upd_valid && !host_mode, "R13 reset state",
            {28'd0, rsp_valid, rsp_err, upd_valid, host_mode}, 32'd0);

        // Directed corners.
        access(16'h09D8, 0, 2'd2, 0, 0);                  // R6 reset value
        access(16'h09D8, 1, 2'd2, 32'h1234_5678, 0);      // R6 write
        access(16'h09D8, 0, 2'd2, 0, 0);
        access(16'h09F8, 1, 2'd2, 32'hFFFF_FFFF, 0);      // R7 write ignored
        access(16'h09F8, 0, 2'd2, 0, 0);
        access(16'h09FC, 0, 2'd2, 0, 0);
        access(16'h0838, 0, 2'd2, 0, 0);
        access(16'h0900, 0, 2'd2, 0, 0);
        access(16'h0100, 1, 2'd2, 32'hDEAD_BEEF, 0);      // R8 unmapped
        access(16'h0100, 0, 2'd2, 0, 0);
        access(16'h0A00, 0, 2'd2, 0, 0);
        access(16'h0800, 1, 2'd2, 32'h0001_0000, 0);      // R11 host mode on
        access(16'h0800, 1, 2'd2, 32'h0000_8000, 0);      // R11 rejected
        access(16'h0800, 0, 2'd2, 0, 0);
        access(16'h09C4, 1, 2'd2, 32'hCAFE_F00D, 0);      // R5 scratch
        access(16'h09C4, 1, 2'd0, 32'h0000_0011, 0);      // R12 byte write rejected
        access(16'h09C4, 0, 2'd1, 0, 0);                  // R12 halfword read
        access(16'h09C4, 0, 2'd2, 0, 0);
        access(16'h0908, 1, 2'd2, 32'hFFFF_FFBF, 0);      // R9 mask + dir
        access(16'h0908, 0, 2'd2, 0, 0);
        access(16'h0908, 1, 2'd1, 32'h0000_0085, 0);      // R12 no update
        access(16'h0944, 1, 2'd2, 32'hFFFF_FFFF, 0);      // R10 last IN slot
        access(16'h0984, 1, 2'd2, 32'h8000_0042, 0);      // R10 last OUT slot
        access(16'h0988, 1, 2'd2, 32'h5555_5555, 0);      // R8 past OUT bank
        access(16'h0988, 0, 2'd2, 0, 0);
        access(16'hF7FC, 0, 2'd0, 0, 2);                  // R1/R3 fifo, high bits set
        access(16'h0600, 1, 2'd1, 32'h0000_BEEF, 0);      // R3 first slice
        access(16'hA5FF, 0, 2'd2, 0, 3);                  // R1/R2 core window

        // Constrained random mix.
        for (int n = 0; n < 800; n++) begin
            logic [ADDR_W-1:0] a;
            logic [1:0] sz;
            bit wr;
            int cat;
            cat = $urandom_range(0, 9);
            wr  = $urandom_range(0, 1) == 1;
            sz  = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(0, 3)) : 2'd2;
            a   = 16'($urandom_range(0, 65535));
            if (cat < 6)      a[11:0] = pick_local();
            else if (cat < 9) a[11:0] = 12'h400 + 12'($urandom_range(0, 1023));
            else              a[11:0] = 12'($urandom_range(0, 1023));
            access(a, wr, sz, $urandom, $urandom_range(0, 3));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule